// File: doc/BRIEF.md
# Two-Tier Interrupt Controller With Grouped Sub-Sources

This block collects up to 32 main interrupt sources and 15 sub-sources and presents one interrupt request line to a processor. Several peripherals raise more than one kind of event. Their events arrive as sub-sources, each with its own pending bit and mask bit. Inside the block, each group of sub-sources is folded into a single parent main-source bit. The grouping and the parent positions are fixed.

Main sources latch into a source-pending register. Those that are not masked compete for a single-hot interrupt-pending register, and the lowest-numbered source wins. The request line stays high while that register holds a bit. Software acknowledges a source in two steps. It first clears the source's bit in source-pending, then the same bit in interrupt-pending, using write-one-to-clear accesses on a small register bus. The next winner is then picked automatically.

Top module: `cascade_intc`

## Requirements
- R1: After reset the main mask (offset 1) reads 0xFFFFFFFF, the sub-mask (offset 4) reads 0x00007FFF, source-pending (offset 0), interrupt-pending (offset 2) and sub-pending (offset 3) read 0, and `irqOut` is low.
- R2: A main source input that is high at a clock edge sets its source-pending bit at that edge, whether or not it is masked, and the bit stays set after the input falls.
- R3: Offsets 0, 2 and 3 are write-one-to-clear: a 1 in the write data clears that bit and a 0 leaves it as it was; offsets 1 and 4 are plain read/write registers; offsets 5 to 7 read as 0; sub-source registers occupy data bits 14:0.
- R4: A main source whose mask bit is 1 never enters interrupt-pending, and with all sources masked `irqOut` stays low.
- R5: When interrupt-pending is empty, the next edge loads it with only the lowest-numbered source that is pending and unmasked; it then holds until cleared; `irqOut` is high exactly while it is non-zero.
- R6: Clearing source-pending and then interrupt-pending for the active source lets the next pending source be selected; clearing interrupt-pending alone while the source bit is still pending reselects the same source.
- R7: Main source positions 6 and 24 never become pending and are never selected.
- R8: Sub-source bits 0-2 feed main bit 28, bits 3-5 feed bit 23, bits 6-8 feed bit 15, bits 9-10 feed bit 31, bits 11-12 feed bit 5, and bits 13-14 feed bit 9.
- R9: A sub-source input that is high sets its sub-pending bit, even when it is sub-masked. The bit reaches its parent only while it is pending and its sub-mask bit is 0. Clearing the sub-mask bit later lets an already pending sub-source set the parent.
- R10: A parent source-pending bit cannot be cleared while any unmasked sub-source of its group is still pending. Once the sub-pending bits are cleared, a clear of the parent takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 32 | Main source request levels |
| subIn | input | 15 | Sub-source request levels |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the two-step acknowledge. A controller that reloads from a stale source bit, or never reloads, either repeats the same source forever or drops the next one. It checks that a parent cannot be cleared while an unmasked sub-source is still pending. A design that let the clear win would lose events that are still outstanding. Each of the 15 sub-source positions is pulsed alone, which exposes any miswired group or parent. Further checks cover the reserved positions, priority under partial masking, and a sub-source that is unmasked only after it became pending. These catch a controller that samples sub-sources only through the mask, or that lets reserved sources through.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int NUM_SRC = 32;
  localparam int NUM_SUB = 15;
  localparam int ADDR_W  = 3;
  localparam int NUM_GRP = 6;

  // fixed sub-source grouping: low bit, high bit, parent main bit
  localparam int GRP_LO [NUM_GRP] = '{0, 3, 6, 9, 11, 13};
  localparam int GRP_HI [NUM_GRP] = '{2, 5, 8, 10, 12, 14};
  localparam int GRP_PAR[NUM_GRP] = '{28, 23, 15, 31, 5, 9};

  localparam logic [NUM_SRC-1:0] RESV_MASK = (NUM_SRC'(1) << 6) | (NUM_SRC'(1) << 24);

  typedef enum logic [2:0] {
    RS_SRCPEND = 3'd0,
    RS_MASK    = 3'd1,
    RS_INTPEND = 3'd2,
    RS_SUBPEND = 3'd3,
    RS_SUBMASK = 3'd4,
    RS_NONE    = 3'd7
  } rd_sel_e;

  typedef struct packed {
    logic    wrSrcPend;
    logic    wrMask;
    logic    wrIntPend;
    logic    wrSubPend;
    logic    wrSubMask;
    rd_sel_e rdSel;
  } ctrl_strb_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
(
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrl_strb_t        strb
);
  always_comb begin
    strb = '{wrSrcPend: 1'b0, wrMask: 1'b0, wrIntPend: 1'b0,
             wrSubPend: 1'b0, wrSubMask: 1'b0, rdSel: RS_NONE};
    case (busAddr)
      3'd0: begin strb.wrSrcPend = busWr; strb.rdSel = RS_SRCPEND; end
      3'd1: begin strb.wrMask    = busWr; strb.rdSel = RS_MASK;    end
      3'd2: begin strb.wrIntPend = busWr; strb.rdSel = RS_INTPEND; end
      3'd3: begin strb.wrSubPend = busWr; strb.rdSel = RS_SUBPEND; end
      3'd4: begin strb.wrSubMask = busWr; strb.rdSel = RS_SUBMASK; end
      default: strb.rdSel = RS_NONE;
    endcase
  end
endmodule

// File: rtl/cic_prio.sv
module cic_prio #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cand,
  output logic [WIDTH-1:0] winner
);
  // isolate the lowest set bit
  assign winner = cand & (~cand + WIDTH'(1));
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strb_t         strb,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SUB-1:0] subIn,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic [NUM_SRC-1:0] srcPendQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] intPendQ,
  output logic [NUM_SUB-1:0] subPendQ,
  output logic [NUM_SUB-1:0] subMaskQ,
  output logic               irqOut
);
  logic [NUM_SUB-1:0] subLive;
  logic [NUM_SRC-1:0] cascadeSet;
  logic [NUM_SRC-1:0] srcSet;
  logic [NUM_SRC-1:0] srcClr;
  logic [NUM_SUB-1:0] subClr;
  logic [NUM_SRC-1:0] candidate;
  logic [NUM_SRC-1:0] winner;

  assign subLive = subPendQ & ~subMaskQ;

  always_comb begin
    cascadeSet = '0;
    for (int b = 0; b < NUM_SUB; b++) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (b >= GRP_LO[g] && b <= GRP_HI[g] && subLive[b])
          cascadeSet[GRP_PAR[g]] = 1'b1;
      end
    end
  end

  assign srcSet    = (srcIn | cascadeSet) & ~RESV_MASK;
  assign srcClr    = strb.wrSrcPend ? busWdata : '0;
  assign subClr    = strb.wrSubPend ? busWdata[NUM_SUB-1:0] : '0;
  assign candidate = srcPendQ & ~maskQ & ~RESV_MASK;

  cic_prio #(.WIDTH(NUM_SRC)) uPrio (
    .cand  (candidate),
    .winner(winner)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPendQ <= '0;
      maskQ    <= '1;
      intPendQ <= '0;
      subPendQ <= '0;
      subMaskQ <= '1;
    end else begin
      srcPendQ <= ((srcPendQ & ~srcClr) | srcSet) & ~RESV_MASK;
      subPendQ <= (subPendQ & ~subClr) | subIn;
      if (strb.wrMask)    maskQ    <= busWdata;
      if (strb.wrSubMask) subMaskQ <= busWdata[NUM_SUB-1:0];
      if (strb.wrIntPend)
        intPendQ <= intPendQ & ~busWdata;
      else if (intPendQ == '0)
        intPendQ <= winner;
    end
  end

  assign irqOut = |intPendQ;

  always_comb begin
    case (strb.rdSel)
      RS_SRCPEND: busRdata = srcPendQ;
      RS_MASK:    busRdata = maskQ;
      RS_INTPEND: busRdata = intPendQ;
      RS_SUBPEND: busRdata = {{(NUM_SRC-NUM_SUB){1'b0}}, subPendQ};
      RS_SUBMASK: busRdata = {{(NUM_SRC-NUM_SUB){1'b0}}, subMaskQ};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SUB-1:0] subIn,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               irqOut
);
  ctrl_strb_t         strb;
  logic [NUM_SRC-1:0] srcPendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] intPendQ;
  logic [NUM_SUB-1:0] subPendQ;
  logic [NUM_SUB-1:0] subMaskQ;

  cic_ctrl uCtrl (
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  cic_datapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcIn   (srcIn),
    .subIn   (subIn),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .srcPendQ(srcPendQ),
    .maskQ   (maskQ),
    .intPendQ(intPendQ),
    .subPendQ(subPendQ),
    .subMaskQ(subMaskQ),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/cic_checker.sv
module cic_checker
  import cic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_SUB-1:0] subIn,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [NUM_SRC-1:0] srcPendQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] intPendQ,
  input logic [NUM_SUB-1:0] subPendQ,
  input logic [NUM_SUB-1:0] subMaskQ
);
  function automatic logic [NUM_SUB-1:0] grpSel(int g);
    logic [NUM_SUB-1:0] s;
    s = '0;
    for (int b = 0; b < NUM_SUB; b++)
      if (b >= GRP_LO[g] && b <= GRP_HI[g]) s[b] = 1'b1;
    return s;
  endfunction

  logic intWr;
  assign intWr = busWr && (busAddr == 3'd2);

  // R5: interrupt-pending is single-hot
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(intPendQ));

  // R5: an occupied interrupt-pending holds unless written
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (intPendQ != '0 && !intWr) |=> $stable(intPendQ));

  // R5/R4: empty register with an unmasked pending source loads one bit
  a_r5_load: assert property (@(posedge clk) disable iff (!rstN)
    (intPendQ == '0 && !intWr && (srcPendQ & ~maskQ) != '0) |=> $onehot(intPendQ));

  // R7: reserved positions never pending or selected
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rstN)
    ((srcPendQ & RESV_MASK) == '0) && ((intPendQ & RESV_MASK) == '0));

  // R2: a high source is captured at the edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & ~RESV_MASK) != '0) |=>
      ((srcPendQ & $past(srcIn & ~RESV_MASK)) == $past(srcIn & ~RESV_MASK)));

  // R9: a high sub-source is captured even when sub-masked
  a_r9_sub_capture: assert property (@(posedge clk) disable iff (!rstN)
    (subIn != '0) |=> ((subPendQ & $past(subIn)) == $past(subIn)));

  // R10: parent held while any unmasked sub-source of its group is pending
  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    localparam logic [NUM_SUB-1:0] SEL = grpSel(g);
    a_r10_parent_hold: assert property (@(posedge clk) disable iff (!rstN)
      ((subPendQ & ~subMaskQ & SEL) != '0) |=> srcPendQ[GRP_PAR[g]]);
  end
endmodule

bind cascade_intc cic_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .srcIn   (srcIn),
  .subIn   (subIn),
  .busWr   (busWr),
  .busAddr (busAddr),
  .srcPendQ(srcPendQ),
  .maskQ   (maskQ),
  .intPendQ(intPendQ),
  .subPendQ(subPendQ),
  .subMaskQ(subMaskQ)
);

// File: tb/cascade_intc_test.sv
`timescale 1ns/1ps
module cascade_intc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [14:0] subIn = '0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [31:0] RESV = 32'h0100_0040;

  typedef struct packed {
    logic [31:0] maskV;
    logic [31:0] srcV;
    logic [31:0] expInt;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0001},
    '{32'h0000_0000, 32'h8000_0010, 32'h0000_0010},
    '{32'h0000_0010, 32'h8000_0010, 32'h8000_0000},
    '{32'hFFFF_FFFF, 32'h0000_FF00, 32'h0000_0000},
    '{32'h0000_0000, 32'h0100_0040, 32'h0000_0000},
    '{32'h0000_0000, 32'h0100_0041, 32'h0000_0001},
    '{32'h0000_000F, 32'h0000_00FF, 32'h0000_0010},
    '{32'h0000_0000, 32'h0080_0000, 32'h0080_0000}
  };

  cascade_intc uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .subIn(subIn),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulseSrc(input logic [31:0] v);
    @(negedge clk); srcIn = v;
    @(negedge clk); srcIn = '0;
  endtask

  task automatic pulseSub(input logic [14:0] v);
    @(negedge clk); subIn = v;
    @(negedge clk); subIn = '0;
    @(negedge clk);
  endtask

  task automatic clearAll();
    busWrite(3'd3, 32'hFFFF_FFFF);
    busWrite(3'd0, 32'hFFFF_FFFF);
    busWrite(3'd2, 32'hFFFF_FFFF);
  endtask

  function automatic int parentOf(int i);
    if (i <= 2)  return 28;
    if (i <= 5)  return 23;
    if (i <= 8)  return 15;
    if (i <= 10) return 31;
    if (i <= 12) return 5;
    return 9;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(3'd0, rd); check("R1 srcPend", rd, 32'h0);
    busRead(3'd1, rd); check("R1 mask", rd, 32'hFFFF_FFFF);
    busRead(3'd2, rd); check("R1 intPend", rd, 32'h0);
    busRead(3'd3, rd); check("R1 subPend", rd, 32'h0);
    busRead(3'd4, rd); check("R1 subMask", rd, 32'h0000_7FFF);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R3 write-zero keeps, write-one clears; unused offset reads 0
    pulseSrc(32'h0000_0008);
    busWrite(3'd0, 32'h0000_0000);
    busRead(3'd0, rd); check("R3 zero write keeps", rd, 32'h0000_0008);
    busWrite(3'd0, 32'h0000_0008);
    busRead(3'd0, rd); check("R3 one write clears", rd, 32'h0);
    busRead(3'd5, rd); check("R3 offset5 reads zero", rd, 32'h0);

    // vector table: R2 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      busWrite(3'd1, VEC[v].maskV);
      pulseSrc(VEC[v].srcV);
      @(negedge clk);
      busRead(3'd2, rd); check($sformatf("R5 R4 R7 vec%0d intPend", v), rd, VEC[v].expInt);
      check($sformatf("R5 vec%0d irqOut", v), {31'b0, irqOut}, {31'b0, VEC[v].expInt != 0});
      busRead(3'd0, rd); check($sformatf("R2 R7 vec%0d srcPend", v), rd, VEC[v].srcV & ~RESV);
      clearAll();
    end

    // R6 acknowledge sequence
    busWrite(3'd1, 32'h0);
    pulseSrc(32'h0000_0024);
    busRead(3'd2, rd); check("R6 first winner", rd, 32'h0000_0004);
    busWrite(3'd2, 32'h0000_0004);
    busRead(3'd2, rd); check("R6 reselect same", rd, 32'h0000_0004);
    busWrite(3'd0, 32'h0000_0004);
    busWrite(3'd2, 32'h0000_0004);
    busRead(3'd2, rd); check("R6 next winner", rd, 32'h0000_0020);
    busWrite(3'd0, 32'h0000_0020);
    busWrite(3'd2, 32'h0000_0020);
    busRead(3'd2, rd); check("R6 all acked", rd, 32'h0);
    check("R6 irq low", {31'b0, irqOut}, 32'h0);

    // R8 group mapping, one sub-source at a time
    busWrite(3'd1, 32'hFFFF_FFFF);
    busWrite(3'd4, 32'h0);
    for (int i = 0; i < 15; i++) begin
      pulseSub(15'(1) << i);
      busRead(3'd0, rd); check($sformatf("R8 sub%0d parent", i), rd, 32'h1 << parentOf(i));
      clearAll();
    end

    // R9 sub-masked source pends but does not reach parent
    busWrite(3'd4, 32'h0000_7FFF);
    pulseSub(15'h0400);
    busRead(3'd3, rd); check("R9 sub pends masked", rd, 32'h0000_0400);
    busRead(3'd0, rd); check("R9 masked no parent", rd, 32'h0);
    busWrite(3'd4, 32'h0000_7BFF);
    @(negedge clk);
    busRead(3'd0, rd); check("R9 unmask sets parent", rd, 32'h8000_0000);

    // R10 parent held while sub pending
    busWrite(3'd0, 32'h8000_0000);
    busRead(3'd0, rd); check("R10 parent held", rd, 32'h8000_0000);
    busWrite(3'd3, 32'h0000_0400);
    busWrite(3'd0, 32'h8000_0000);
    busRead(3'd0, rd); check("R10 parent cleared", rd, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule